// File: doc/BRIEF.md
# Variable-Page Fully Associative Translation Lookup

This block translates a virtual address into a physical address. It holds a parameterised number of translation entries (64 by default). Each entry pairs a 64-bit tag with a 64-bit translation word, and all entries are compared against every request at once. A 2-bit size field inside each translation word picks one of four page sizes: 8 KiB, 64 KiB, 512 KiB or 4 MiB. The entry's compare mask widens by three bits for each step of that field.

A request carries a virtual address, a 13-bit address-space context, a user/supervisor flag and a read/write flag. One cycle later the block reports exactly one of three outcomes:

- **Hit**: a physical address and a write-permit flag.
- **Protection fault**: updates a fault status word and captures the faulting address.
- **Miss**: loads a tag-access word that refill logic elsewhere can use.

Entries are loaded through a simple indexed write port. The block does not choose which entry to replace; that is done outside it.

Top module: `tlb_lookup`

## Requirements
- R1: After reset all entries are invalid, no response is flagged (`rsp_valid`, `rsp_hit`, `rsp_fault`, `rsp_miss` low), and `fault_status`, `fault_addr` and `tag_access` are zero.
- R2: A request sampled with `req_valid` high gives `rsp_valid` high in the following cycle, with exactly one of `rsp_hit`, `rsp_fault`, `rsp_miss` set.
- R3: An entry matches when translation bit 63 (valid) is set, tag bits 12:0 equal the request context, and the address equals the tag under the mask 0xFFFFFFFFFFFFE000 shifted left by 3 times translation bits 62:61 (0: 8 KiB, 1: 64 KiB, 2: 512 KiB, 3: 4 MiB).
- R4: On a hit, `rsp_pa` is ((translation & mask) | (va & ~mask)) & 0x1FFFFFFE000, so bits 12:0 and bits above 40 are zero.
- R5: On a hit, `rsp_writable` equals translation bit 1.
- R6: A match is a fault instead of a hit when a user request meets translation bit 2 (privileged) set, or a write request meets translation bit 1 clear; a fault returns `rsp_pa` = 0 and `rsp_writable` = 0.
- R7: On a fault, `fault_status` gets bit 0 set, bit 2 = write flag, bit 3 = user flag, bit 7 = privilege violation, and `fault_addr` takes the request address.
- R8: If `fault_status` bit 0 is already set when a fault occurs, the old value is first replaced by 2 (bit 1, overflow) before the R7 bits are ORed in.
- R9: On a miss, `tag_access` becomes {va[63:13], context}; hits and misses leave `fault_status` and `fault_addr` unchanged.
- R10: When several entries match, the one with the lowest index supplies the result.
- R11: A write through the port takes effect for requests sampled in later cycles; a request in the same cycle as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag to store (address bits 63:13, context bits 12:0) |
| wr_tte | input | 64 | Translation word to store |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 64 | Virtual address |
| req_ctx | input | 13 | Address-space context |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Protection fault |
| rsp_miss | output | 1 | No matching entry |
| rsp_pa | output | 64 | Physical address on hit, zero otherwise |
| rsp_writable | output | 1 | Page write permit on hit |
| fault_status | output | 16 | Accumulated fault status word |
| fault_addr | output | 64 | Address of the latest fault |
| tag_access | output | 64 | Address and context of the latest miss |

## Verification
Every outcome is registered once, so the response flags, `rsp_pa`, `rsp_writable`, `fault_status`, `fault_addr` and `tag_access` all change on the first rising edge after the request edge. The bench drives a request on a falling edge and withdraws it on the next falling edge, then samples the results at that second falling edge. Writes to entries follow the same pattern. In the same-cycle write case, the result sampled one cycle later must still reflect the old entry; only the next request sees the new one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int TLB_ENTRIES = 64;
    localparam int CTX_W       = 13;
    localparam int ADDR_W      = 64;
    localparam int PG_SHIFT    = 13;
    localparam int PA_MSB      = 40;
    localparam int STAT_W      = 16;

    // translation word bit positions
    localparam int TW_VALID  = 63;
    localparam int TW_SZ_LO  = 61;
    localparam int TW_PRIV   = 2;
    localparam int TW_WRITE  = 1;

    // fault status bit positions
    localparam int FS_ACTIVE = 0;
    localparam int FS_OVF    = 1;
    localparam int FS_WRITE  = 2;
    localparam int FS_USER   = 3;
    localparam int FS_PRIV   = 7;

    localparam logic [ADDR_W-1:0] BASE_MASK = {{(ADDR_W-PG_SHIFT){1'b1}}, {PG_SHIFT{1'b0}}};
    localparam logic [ADDR_W-1:0] PA_KEEP   =
        {{(ADDR_W-PA_MSB-1){1'b0}}, {(PA_MSB+1-PG_SHIFT){1'b1}}, {PG_SHIFT{1'b0}}};

    typedef struct packed {
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] tw;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_FAULT = 2'd2,
        OUT_MISS  = 2'd3
    } outcome_e;

    function automatic logic [ADDR_W-1:0] size_mask(input logic [1:0] sz);
        return BASE_MASK << (3 * sz);
    endfunction

    function automatic logic [ADDR_W-1:0] form_pa(input logic [ADDR_W-1:0] tw,
                                                  input logic [ADDR_W-1:0] va);
        logic [ADDR_W-1:0] m;
        m = size_mask(tw[TW_SZ_LO+1:TW_SZ_LO]);
        return ((tw & m) | (va & ~m)) & PA_KEEP;
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = TLB_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0]  wr_tw,
    input  logic [ADDR_W-1:0]  lk_va,
    input  logic [CTX_W-1:0]   lk_ctx,
    output logic [ENTRIES-1:0] match_o,
    output tlb_entry_t         ent_o [ENTRIES]
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_entry_t        slot;
        logic [ADDR_W-1:0] m;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot <= '{tag: wr_tag, tw: wr_tw};
            end
        end

        always_comb begin
            m = size_mask(slot.tw[TW_SZ_LO+1:TW_SZ_LO]);
            match_o[g] = slot.tw[TW_VALID]
                      && (slot.tag[CTX_W-1:0] == lk_ctx)
                      && ((lk_va & m) == (slot.tag & m));
        end

        assign ent_o[g] = slot;
    end

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     match,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_fault_regs.sv
module tlb_fault_regs
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              do_fault,
    input  logic              do_miss,
    input  logic              acc_user,
    input  logic              acc_write,
    input  logic              priv_viol,
    input  logic [ADDR_W-1:0] va,
    input  logic [CTX_W-1:0]  ctx,
    output logic [STAT_W-1:0] fault_status,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ADDR_W-1:0] tag_access
);

    logic [STAT_W-1:0] base, next_status;

    always_comb begin
        base = fault_status;
        if (fault_status[FS_ACTIVE]) begin
            base = '0;
            base[FS_OVF] = 1'b1;
        end
        next_status = base;
        next_status[FS_ACTIVE] = 1'b1;
        if (acc_write) next_status[FS_WRITE] = 1'b1;
        if (acc_user)  next_status[FS_USER]  = 1'b1;
        if (priv_viol) next_status[FS_PRIV]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_status <= '0;
            fault_addr   <= '0;
            tag_access   <= '0;
        end else if (do_fault) begin
            fault_status <= next_status;
            fault_addr   <= va;
        end else if (do_miss) begin
            tag_access   <= {va[ADDR_W-1:PG_SHIFT], ctx};
        end
    end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int ENTRIES = TLB_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_tag,
    input  logic [ADDR_W-1:0] wr_tte,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              req_user,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic              rsp_miss,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_writable,
    output logic [STAT_W-1:0] fault_status,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ADDR_W-1:0] tag_access
);

    logic [ENTRIES-1:0] match;
    tlb_entry_t         ents [ENTRIES];
    logic               found;
    logic [IDX_W-1:0]   win;
    tlb_entry_t         sel;
    logic               priv_viol, wr_viol;
    outcome_e           outcome;

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .wr_tw   (wr_tte),
        .lk_va   (req_va),
        .lk_ctx  (req_ctx),
        .match_o (match),
        .ent_o   (ents)
    );

    tlb_first_hit #(.N(ENTRIES)) u_pick (
        .match (match),
        .found (found),
        .idx   (win)
    );

    always_comb begin
        sel       = ents[win];
        priv_viol = sel.tw[TW_PRIV] & req_user;
        wr_viol   = ~sel.tw[TW_WRITE] & req_write;
        if (!req_valid)                 outcome = OUT_NONE;
        else if (!found)                outcome = OUT_MISS;
        else if (priv_viol || wr_viol)  outcome = OUT_FAULT;
        else                            outcome = OUT_HIT;
    end

    tlb_fault_regs u_fregs (
        .clk          (clk),
        .rst          (rst),
        .do_fault     (outcome == OUT_FAULT),
        .do_miss      (outcome == OUT_MISS),
        .acc_user     (req_user),
        .acc_write    (req_write),
        .priv_viol    (priv_viol),
        .va           (req_va),
        .ctx          (req_ctx),
        .fault_status (fault_status),
        .fault_addr   (fault_addr),
        .tag_access   (tag_access)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_pa       <= '0;
            rsp_writable <= 1'b0;
        end else begin
            rsp_valid    <= outcome != OUT_NONE;
            rsp_hit      <= outcome == OUT_HIT;
            rsp_fault    <= outcome == OUT_FAULT;
            rsp_miss     <= outcome == OUT_MISS;
            rsp_pa       <= (outcome == OUT_HIT) ? form_pa(sel.tw, req_va) : '0;
            rsp_writable <= (outcome == OUT_HIT) ? sel.tw[TW_WRITE] : 1'b0;
        end
    end

endmodule

// File: rtl/tlb_lookup_checker.sv
module tlb_lookup_checker
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [CTX_W-1:0]  req_ctx,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_fault,
    input logic              rsp_miss,
    input logic [ADDR_W-1:0] rsp_pa,
    input logic              rsp_writable,
    input logic [STAT_W-1:0] fault_status,
    input logic [ADDR_W-1:0] fault_addr
);

    a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_fault, rsp_miss}) == 1);

    a_r2_no_stray_outcome: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_miss));

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r4_pa_range: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_pa[PG_SHIFT-1:0] == '0) && (rsp_pa[ADDR_W-1:PA_MSB+1] == '0));

    a_r6_fault_no_pa: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_pa == '0) && !rsp_writable);

    a_r7_fault_active: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> fault_status[FS_ACTIVE]);

    a_r8_overflow: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault && $past(fault_status[FS_ACTIVE])) |-> fault_status[FS_OVF]);

    a_r9_status_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit || rsp_miss) |-> ($stable(fault_status) && $stable(fault_addr)));

    a_r9_miss_ctx: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (tlb_lookup.tag_access[CTX_W-1:0] == $past(req_ctx)));

endmodule

bind tlb_lookup tlb_lookup_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ctx      (req_ctx),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_fault    (rsp_fault),
    .rsp_miss     (rsp_miss),
    .rsp_pa       (rsp_pa),
    .rsp_writable (rsp_writable),
    .fault_status (fault_status),
    .fault_addr   (fault_addr)
);

// File: tb/tlb_lookup_bench.sv
module tlb_lookup_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0, wr_tte = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [12:0] req_ctx = '0;
    logic        req_user = 1'b0, req_write = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_writable;
    logic [63:0] rsp_pa, fault_addr, tag_access;
    logic [15:0] fault_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tlb_lookup u_tlb_lookup (.*);

    typedef struct packed {
        logic [63:0] va;
        logic [12:0] ctx;
        logic        user;
        logic        wr;
        logic [1:0]  kind;   // 1 hit, 2 fault, 3 miss
        logic [63:0] pa;
        logic        pw;
        logic [15:0] st;
        logic [63:0] aux;    // fault address or tag access
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_1234_6ABC, 13'h005, 1'b1, 1'b1, 2'd1, 64'h0ABC_E000,     1'b1, 16'h0000, 64'h0},
        '{64'h0000_0000_1234_6ABC, 13'h006, 1'b0, 1'b0, 2'd3, 64'h0,             1'b0, 16'h0000, 64'h1234_6006},
        '{64'h0000_0040_003F_FFF8, 13'h001, 1'b0, 1'b0, 2'd1, 64'h1_007F_E000,   1'b1, 16'h0000, 64'h0},
        '{64'h0000_0040_0040_0000, 13'h001, 1'b0, 1'b0, 2'd3, 64'h0,             1'b0, 16'h0000, 64'h40_0040_0001},
        '{64'h0000_0040_0012_3456, 13'h001, 1'b1, 1'b0, 2'd2, 64'h0,             1'b0, 16'h0089, 64'h40_0012_3456},
        '{64'h0000_0000_7777_1234, 13'h003, 1'b0, 1'b0, 2'd1, 64'h0055_0000,     1'b0, 16'h0089, 64'h0},
        '{64'h0000_0000_7777_1234, 13'h003, 1'b0, 1'b1, 2'd2, 64'h0,             1'b0, 16'h0007, 64'h7777_1234},
        '{64'h0000_0040_0000_0010, 13'h001, 1'b1, 1'b1, 2'd2, 64'h0,             1'b0, 16'h008F, 64'h40_0000_0010},
        '{64'h0000_0000_0000_2FFF, 13'h1FFF, 1'b1, 1'b0, 2'd1, 64'h100_0001_2000, 1'b1, 16'h008F, 64'h0}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [5:0] idx, input logic [63:0] tag, input logic [63:0] tw);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_tag = tag; wr_tte = tw;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [63:0] va, input logic [12:0] ctx,
                          input logic user, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_ctx = ctx; req_user = user; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1", "flags", 64'({rsp_hit, rsp_fault, rsp_miss}), 64'd0);
        check("R1", "fault_status", 64'(fault_status), 64'd0);
        check("R1", "fault_addr", fault_addr, 64'd0);
        check("R1", "tag_access", tag_access, 64'd0);
        // R1: empty array misses
        lookup(64'h0, 13'h0, 1'b0, 1'b0);
        check("R1", "empty miss", 64'(rsp_miss), 64'd1);

        // entries: 8K writable, 4M priv+writable, 64K read-only, 8K with high junk
        load(6'd5,  64'h0000_0000_1234_6005, 64'h8000_0000_0ABC_E002);
        load(6'd9,  64'h0000_0040_0000_0001, 64'hE000_0001_0040_0006);
        load(6'd2,  64'h0000_0000_7777_0003, 64'hA000_0000_0055_0000);
        load(6'd40, 64'h0000_0000_0000_3FFF, 64'h8000_FF00_0001_2002);

        // R3 R4 R5 R6 R7 R8 R9 table walk
        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].va, VECS[i].ctx, VECS[i].user, VECS[i].wr);
            check("R2", $sformatf("v%0d valid", i), 64'(rsp_valid), 64'd1);
            check("R3", $sformatf("v%0d outcome", i),
                  64'({rsp_hit, rsp_fault, rsp_miss}),
                  (VECS[i].kind == 2'd1) ? 64'd4 : (VECS[i].kind == 2'd2) ? 64'd2 : 64'd1);
            check("R4", $sformatf("v%0d pa", i), rsp_pa, VECS[i].pa);
            check("R5", $sformatf("v%0d writable", i), 64'(rsp_writable), 64'(VECS[i].pw));
            check("R8", $sformatf("v%0d status", i), 64'(fault_status), 64'(VECS[i].st));
            if (VECS[i].kind == 2'd2)
                check("R7", $sformatf("v%0d fault_addr", i), fault_addr, VECS[i].aux);
            if (VECS[i].kind == 2'd3)
                check("R9", $sformatf("v%0d tag_access", i), tag_access, VECS[i].aux);
        end
        // R9: hit after miss keeps fault address of last fault
        check("R9", "fault_addr kept", fault_addr, 64'h40_0000_0010);

        // R10 lowest index wins among overlapping 512K entries
        load(6'd30, 64'h0000_0000_0080_0007, 64'hC000_0000_00B8_0002);
        load(6'd20, 64'h0000_0000_0080_0007, 64'hC000_0000_00A0_0002);
        lookup(64'h0000_0000_0080_ABCD, 13'h007, 1'b0, 1'b0);
        check("R10", "low index pa", rsp_pa, 64'h00A0_A000);
        load(6'd20, 64'h0, 64'h0);
        lookup(64'h0000_0000_0080_ABCD, 13'h007, 1'b0, 1'b0);
        check("R10", "next index pa", rsp_pa, 64'h00B8_A000);

        // R11 write and lookup in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd50;
        wr_tag = 64'h0000_0001_0000_00AA; wr_tte = 64'h8000_0000_00C0_0002;
        req_valid = 1'b1; req_va = 64'h0000_0001_0000_0000; req_ctx = 13'h0AA;
        req_user = 1'b0; req_write = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R11", "same-cycle miss", 64'(rsp_miss), 64'd1);
        check("R11", "same-cycle tag_access", tag_access, 64'h1_0000_00AA);
        lookup(64'h0000_0001_0000_0000, 13'h0AA, 1'b0, 1'b0);
        check("R11", "later hit", 64'(rsp_hit), 64'd1);
        check("R11", "later pa", rsp_pa, 64'h00C0_0000);
        check("R9", "status kept", 64'(fault_status), 64'h008F);

        // R2: idle cycle gives no response
        @(negedge clk);
        check("R2", "idle", 64'(rsp_valid), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule